// File: doc/BRIEF.md
# Mark-Delimited Serial Decimal Field Adder

This block adds two decimal fields that live in a character-addressed memory and writes the sum back over the second field. A field has no length register. Its high-order end is the character whose mark bit is set. The caller supplies the address of the low-order character of each field and a one-cycle start pulse. The block then walks both fields from right to left, one character per step, using a single-port synchronous RAM. For each character it reads from the first field (A), reads from the second field (B), and then writes B. Only the current A digit and a few address registers are held inside the block, so the fields can be of any length.

When field A runs out before field B, the rest of B still receives the carry, with zero taken as the A digit, and A is no longer read. The operation stops on the B character that carries the mark. The block then raises a one-cycle done pulse and presents the final decimal carry as an overflow flag. It also presents a sticky flag that reports any character read with bad parity.

The controller is a five-state machine:
- `ST_IDLE` waits for start. Transition *launch*: start is seen, the block loads its pointers and goes to `ST_FETCH_A`.
- `ST_FETCH_A` puts the A pointer on the bus. Transition *to_b*: the block goes to `ST_FETCH_B`.
- `ST_FETCH_B` captures the A character and puts the B pointer on the bus. Transition *to_write*: the block goes to `ST_WRITE_B`.
- `ST_WRITE_B` adds the digits and writes B. It then takes one of three transitions:
  - *next_pair*: A is still live, so it goes to `ST_FETCH_A`.
  - *next_b_only*: A is exhausted, so it goes to `ST_FETCH_B`.
  - *finish*: the B mark was seen, so it goes to `ST_DONE`.
- `ST_DONE` pulses done. Transition *release*: the block goes back to `ST_IDLE`.

Top module: `fldadd_serial`

## Requirements
- R1: While reset is held and afterwards until a start is accepted, busy, done and mem_we are 0.
- R2: A stored character is 8 bits, laid out as follows:
  - bit 7 is the field mark.
  - bit 6 is odd parity, chosen so that bits 6..0 hold an odd number of ones.
  - bits 5..4 are a zone.
  - bits 3..0 are a BCD digit.
- R3: A start seen in idle launches an operation. busy is 1 from the next cycle through the done cycle and 0 the cycle after. A start that arrives while busy has no effect.
- R4: For each character pair the block reads A at its pointer, reads B at its pointer in the next cycle, and writes B at the same address in the cycle after that. Read data returns one cycle after the address. Both pointers step down by one after each pair.
- R5: The written digit is (A digit + B digit + carry) mod 10, and the carry into the next step is 1 when that sum is 10 or more. The carry into the first step is 0.
- R6: The written character keeps the mark and the zone of the B character it replaces and carries freshly generated odd parity.
- R7: The operation ends after the B character with the mark is written. done is high for exactly one cycle. carry_out then holds the final carry until the next start.
- R8: Once the A character with the mark has been added, A is not read again and its digit counts as zero. Each remaining B character takes two cycles, so a run lasts 3·min(LA,LB) + 2·(LB − min(LA,LB)) cycles from the launching edge to done.
- R9: Any character read with even parity (A or B) sets par_err. The flag holds until the next start, and the add continues unchanged.
- R10: When B is shorter than A, no memory location outside field B is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin an add |
| a_addr | input | ADDR_W | Address of the low-order character of field A |
| b_addr | input | ADDR_W | Address of the low-order character of field B |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| carry_out | output | 1 | Final decimal carry (overflow) |
| par_err | output | 1 | A character with bad parity was read |
| mem_addr | output | ADDR_W | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Character written to memory |
| mem_rdata | input | 8 | Character read, valid one cycle after its address |

## Verification
The digit-range property assumes that both operands hold valid BCD digits. The write-address property assumes a memory with one cycle of read latency that returns data from the address of the previous cycle. The bench builds every field from decimal values, so its digits are always 0 to 9. The one parity fault it injects flips only the parity bit, so the data bits stay valid. The bench also places fields so that A and B never overlap and a sentinel character sits beside B, which makes any stray write visible.

// File: rtl/fldadd_pkg.sv
package fldadd_pkg;
    localparam int CHAR_W  = 8;
    localparam int DATA_W  = 6;
    localparam int DIGIT_W = 4;
    localparam int ZONE_W  = DATA_W - DIGIT_W;
    localparam int WM_BIT  = CHAR_W - 1;
    localparam int PAR_BIT = CHAR_W - 2;
    localparam int RADIX   = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_A,
        ST_FETCH_B,
        ST_WRITE_B,
        ST_DONE
    } fa_state_t;
endpackage

// File: rtl/fldadd_parity.sv
module fldadd_parity #(
    parameter int DATA_W = 6
) (
    input  logic [DATA_W-1:0] data,
    input  logic              par_in,
    output logic              par_gen,
    output logic              par_ok
);
    // odd parity: generated bit makes the total count of ones odd
    assign par_gen = ~(^data);
    assign par_ok  = ^{par_in, data};
endmodule

// File: rtl/fldadd_digit.sv
module fldadd_digit #(
    parameter int DIGIT_W = 4,
    parameter int RADIX   = 10
) (
    input  logic [DIGIT_W-1:0] a,
    input  logic [DIGIT_W-1:0] b,
    input  logic               cin,
    output logic [DIGIT_W-1:0] sum,
    output logic               cout
);
    localparam logic [DIGIT_W:0] RAD = (DIGIT_W+1)'(RADIX);

    logic [DIGIT_W:0] raw;
    logic [DIGIT_W:0] wrapped;

    always_comb begin
        raw     = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, cin};
        wrapped = raw - RAD;
        if (raw >= RAD) begin
            cout = 1'b1;
            sum  = wrapped[DIGIT_W-1:0];
        end else begin
            cout = 1'b0;
            sum  = raw[DIGIT_W-1:0];
        end
    end
endmodule

// File: rtl/fldadd_serial.sv
module fldadd_serial
    import fldadd_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              busy,
    output logic              done,
    output logic              carry_out,
    output logic              par_err,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [CHAR_W-1:0] mem_wdata,
    input  logic [CHAR_W-1:0] mem_rdata
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    fa_state_t          state, state_nx;
    logic [ADDR_W-1:0]  a_ptr, b_ptr;
    logic [DIGIT_W-1:0] a_dig;
    logic               carry;
    logic               a_end;
    logic               err_q;
    logic               cout_q;

    logic               rd_par_ok;
    logic               wr_par;
    logic [DIGIT_W-1:0] sum_dig;
    logic               sum_cout;
    logic               rd_mark;

    assign rd_mark = mem_rdata[WM_BIT];

    // parity check of the character on the read bus
    fldadd_parity #(.DATA_W(DATA_W)) u_rd_par (
        .data    (mem_rdata[DATA_W-1:0]),
        .par_in  (mem_rdata[PAR_BIT]),
        .par_gen (),
        .par_ok  (rd_par_ok)
    );

    // parity generation for the written character
    fldadd_parity #(.DATA_W(DATA_W)) u_wr_par (
        .data    ({mem_rdata[DATA_W-1:DIGIT_W], sum_dig}),
        .par_in  (1'b0),
        .par_gen (wr_par),
        .par_ok  ()
    );

    fldadd_digit #(.DIGIT_W(DIGIT_W), .RADIX(RADIX)) u_digit (
        .a    (a_dig),
        .b    (mem_rdata[DIGIT_W-1:0]),
        .cin  (carry),
        .sum  (sum_dig),
        .cout (sum_cout)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_FETCH_A;           // launch
            ST_FETCH_A: state_nx = ST_FETCH_B;                      // to_b
            ST_FETCH_B: state_nx = ST_WRITE_B;                      // to_write
            ST_WRITE_B: begin
                if (rd_mark)    state_nx = ST_DONE;                 // finish
                else if (a_end) state_nx = ST_FETCH_B;              // next_b_only
                else            state_nx = ST_FETCH_A;              // next_pair
            end
            ST_DONE:    state_nx = ST_IDLE;                         // release
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            a_ptr  <= '0;
            b_ptr  <= '0;
            a_dig  <= '0;
            carry  <= 1'b0;
            a_end  <= 1'b0;
            err_q  <= 1'b0;
            cout_q <= 1'b0;
        end else begin
            state <= state_nx;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        a_ptr  <= a_addr;
                        b_ptr  <= b_addr;
                        a_dig  <= '0;
                        carry  <= 1'b0;
                        a_end  <= 1'b0;
                        err_q  <= 1'b0;
                        cout_q <= 1'b0;
                    end
                end
                ST_FETCH_A: ;
                ST_FETCH_B: begin
                    if (!a_end) begin
                        a_dig <= mem_rdata[DIGIT_W-1:0];
                        if (!rd_par_ok) err_q <= 1'b1;
                        if (rd_mark)    a_end <= 1'b1;
                    end
                end
                ST_WRITE_B: begin
                    carry <= sum_cout;
                    if (!rd_par_ok) err_q <= 1'b1;
                    if (rd_mark) begin
                        cout_q <= sum_cout;
                    end else begin
                        b_ptr <= b_ptr - ONE;
                        if (a_end) a_dig <= '0;
                        else       a_ptr <= a_ptr - ONE;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        mem_we    = (state == ST_WRITE_B);
        mem_addr  = (state == ST_FETCH_A) ? a_ptr : b_ptr;
        mem_wdata = {rd_mark, wr_par, mem_rdata[DATA_W-1:DIGIT_W], sum_dig};
        carry_out = cout_q;
        par_err   = err_q;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!mem_we && !done));

    // R4
    write_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == $past(mem_addr)) && !$past(mem_we));

    // R6
    wr_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (^mem_wdata[PAR_BIT:0]));

    // R6
    wr_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata[WM_BIT] == mem_rdata[WM_BIT]));

    // R5
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && (a_dig < DIGIT_W'(RADIX)) && (mem_rdata[DIGIT_W-1:0] < DIGIT_W'(RADIX)))
        |-> (mem_wdata[DIGIT_W-1:0] < DIGIT_W'(RADIX)));

    // R3
    busy_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R8
    a_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE_B && a_end && !rd_mark) |=> (state == ST_FETCH_B));
endmodule

// File: tb/fldadd_serial_tb.sv
`timescale 1ns/1ps
module fldadd_serial_tb;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] a_addr = '0;
    logic [AW-1:0] b_addr = '0;
    logic          busy, done, carry_out, par_err;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata;

    logic [7:0] mem [0:(1<<AW)-1];

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    fldadd_serial #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .a_addr(a_addr), .b_addr(b_addr),
        .busy(busy), .done(done), .carry_out(carry_out), .par_err(par_err),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    function automatic logic [7:0] mk_char(input bit wm, input logic [1:0] zone, input logic [3:0] dig);
        return {wm, ~(^{zone, dig}), zone, dig};
    endfunction

    function automatic int pow10(input int n);
        int r = 1;
        for (int i = 0; i < n; i++) r = r * 10;
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load_field(input int lo, input int len, input int val, input logic [1:0] zone);
        for (int i = 0; i < len; i++)
            mem[lo - i] = mk_char(i == len - 1, zone, 4'((val / pow10(i)) % 10));
    endtask

    // generic add scenario with full result checking
    task automatic run_add(input string name, input int a_lo, input int la, input int a_val,
                           input int b_lo, input int lb, input int b_val, input logic [1:0] bzone,
                           input int bad_a_idx, input bit inject);
        int m, a_eff, total, exp_res, cnt;
        bit exp_c;
        logic [7:0] sent_hi, sent_lo, ch;
        for (int i = 0; i < (1<<AW); i++) mem[i] = 8'h40;
        load_field(a_lo, la, a_val, 2'b01);
        load_field(b_lo, lb, b_val, bzone);
        sent_hi = mk_char(1'b1, 2'b11, 4'd9);
        sent_lo = mk_char(1'b0, 2'b10, 4'd7);
        mem[b_lo - lb] = sent_hi;
        mem[b_lo + 1]  = sent_lo;
        if (bad_a_idx >= 0) mem[a_lo - bad_a_idx][6] = ~mem[a_lo - bad_a_idx][6];
        m       = (la < lb) ? la : lb;
        a_eff   = a_val % pow10(lb);
        total   = a_eff + b_val;
        exp_c   = (total >= pow10(lb));
        exp_res = total % pow10(lb);

        @(negedge clk);
        a_addr = AW'(a_lo); b_addr = AW'(b_lo); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, {name, " R3 busy after start"}, busy, 1);
        cnt = 0;
        while (!done && cnt < 200) begin
            if (inject && cnt == 1) begin
                start = 1'b1; a_addr = AW'(a_lo - 50); b_addr = AW'(b_lo - 50);
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        check(cnt == 3*m + 2*(lb - m), {name, " R4 R8 cycles to done"}, cnt, 3*m + 2*(lb - m));
        check(busy == 1'b1, {name, " R3 busy during done"}, busy, 1);
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, {name, " R7 done one cycle"}, done, 0);
        check(busy == 1'b0, {name, " R3 busy low after done"}, busy, 0);
        check(carry_out == exp_c, {name, " R7 carry_out"}, carry_out, exp_c);
        check(par_err == (bad_a_idx >= 0), {name, " R9 par_err"}, par_err, bad_a_idx >= 0);
        for (int i = 0; i < lb; i++) begin
            ch = mem[b_lo - i];
            check(ch[3:0] == 4'((exp_res / pow10(i)) % 10), {name, " R5 digit"}, ch[3:0], (exp_res / pow10(i)) % 10);
            check(ch[5:4] == bzone, {name, " R6 zone kept"}, ch[5:4], bzone);
            check(ch[7] == (i == lb - 1), {name, " R6 mark kept"}, ch[7], i == lb - 1);
            check(^ch[6:0] == 1'b1, {name, " R2 R6 odd parity"}, ^ch[6:0], 1);
        end
        check(mem[b_lo - lb] == sent_hi, {name, " R10 above B untouched"}, mem[b_lo - lb], sent_hi);
        check(mem[b_lo + 1] == sent_lo, {name, " R10 below B untouched"}, mem[b_lo + 1], sent_lo);
        @(posedge clk);
        @(negedge clk);
        check(carry_out == exp_c, {name, " R7 carry_out held"}, carry_out, exp_c);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        check(done == 1'b0, "R1 done in reset", done, 0);
        check(mem_we == 1'b0, "R1 mem_we in reset", mem_we, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && mem_we == 1'b0, "R1 idle after reset", busy, 0);
    endtask

    task automatic t_basic;       run_add("basic",     100, 3, 123,   200, 3, 456, 2'b00, -1, 1'b0); endtask
    task automatic t_a_short;     run_add("a_short",   100, 1, 1,     200, 3, 999, 2'b10, -1, 1'b0); endtask
    task automatic t_b_short;     run_add("b_short",   100, 5, 12345, 200, 2, 99,  2'b01, -1, 1'b0); endtask
    task automatic t_single;      run_add("single",    300, 1, 7,     400, 1, 8,   2'b11, -1, 1'b0); endtask
    task automatic t_parity;      run_add("parity",    100, 3, 404,   200, 3, 111, 2'b00,  1, 1'b0); endtask
    task automatic t_busy_start;  run_add("busy_start",500, 3, 250,   600, 4, 250, 2'b00, -1, 1'b1); endtask

    initial begin
        for (int i = 0; i < (1<<AW); i++) mem[i] = 8'h40;
        repeat (3) @(posedge clk);
        t_reset();
        t_basic();
        t_a_short();
        t_b_short();
        t_single();
        t_parity();
        t_busy_start();
        t_basic();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule